// File: doc/BRIEF.md
# Receive Idle Insertion Jitter Buffer

This block sits in a burst-mode receive PCS after the FEC decoder has removed parity. The block stream that reaches it is no longer continuous. Wherever a parity region was removed, the valid strobe drops, and a one-cycle marker flags that a region was cut out. The block rebuilds a constant-rate stream of 66-bit blocks, so that every frame leaves after the same delay no matter how long it is.

Every incoming valid block is written into a FIFO, and there is no bypass path. Output starts only after the FIFO has been primed with enough blocks to cover the largest amount of parity one frame can lose. From then on the block emits one block per cycle. At the write side it counts the parity regions removed inside the current frame and stores that count with the frame's terminate block. When that terminate block reaches the output, reads from the FIFO pause and four IDLE blocks are emitted for each counted region. The stream therefore regains the slots that parity occupied on the line, and the IDLEs land after the frame rather than inside it.

Top module: `rx_idle_restore`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `out_valid` is 0, `overflow` is 0, and `out_block` carries the IDLE control block. The IDLE control block is bits [65:64] = 2'b10, bits [63:56] = 8'h1E and bits [55:0] = 0.
- R2: `out_valid` stays 0, and `out_block` stays IDLE, until PRIME blocks (default 32) have been buffered. The first block written after reset appears on `out_block` exactly PRIME+1 cycles after the clock edge that wrote it, and `out_valid` rises in that same cycle.
- R3: Every block written with `in_valid` = 1 appears on the output exactly once, in write order. The only blocks added to the stream are inserted IDLEs.
- R4: A terminate block has bits [65:64] = 2'b10 and a type byte in bits [63:56] equal to one of 87, 99, AA, B4, CC, D2, E1 or FF (hex). After it is output, exactly 4×n IDLE blocks follow before the next buffered block. Here n is the number of cycles with `in_parity_cut` = 1 since the most recent start block was written.
- R5: A start block has bits [65:64] = 2'b10 and type byte 8'h78. Every start block leaves exactly PRIME+1 cycles after it was written, whatever the length and parity count of the frames before it. This holds when each marked region comes with four cycles of `in_valid` = 0 inside the frame.
- R6: Writing a start block clears the parity count. Markers seen between frames add no IDLEs to the next frame.
- R7: Once `out_valid` has risen, it stays 1 every cycle until reset. When the FIFO is empty and no IDLEs are owed, the block emits IDLE.
- R8: A marker arriving when MAX_REGIONS (default 8) regions have already been counted in the current frame sets `overflow`. The count owed for that frame stays capped at MAX_REGIONS.
- R9: A write attempted while the FIFO holds DEPTH blocks is dropped and sets `overflow`. `overflow` stays set until reset.
- R10: Reset empties the FIFO and clears the priming state. With no new writes after reset, `out_valid` stays 0 and nothing buffered before the reset reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | `in_block` carries a block to buffer |
| in_block | input | 66 | Received block: [65:64] sync header, [63:56] type byte for control blocks |
| in_parity_cut | input | 1 | One pulse per parity region removed from the stream |
| out_valid | output | 1 | Output stream running (set once primed) |
| out_block | output | 66 | Constant-rate output block |
| overflow | output | 1 | Sticky error: FIFO full on write, or too many regions in a frame |

## Verification
The properties hold for any input sequence, including markers with no gaps, back-to-back frames and a FIFO driven to full. None of them assumes the input follows the gap-per-region rule. The fixed-latency behaviour, however, relies on each marker coming with four empty input cycles inside its frame, and on enough inter-frame blocks for the owed IDLEs to be paid before the next frame loses parity. The main stimulus keeps within that rule: each region is a four-cycle gap inside the frame, and forty IDLE blocks separate frames. The overflow cases deliberately break it, with markers that carry no gaps, and are checked only through the `overflow` flag and reset behaviour.

// File: rtl/rx_idle_restore_pkg.sv
package rx_idle_restore_pkg;

   localparam int BLK_W = 66;

   localparam logic [1:0] SYNC_CTRL  = 2'b10;
   localparam logic [7:0] TYPE_IDLE  = 8'h1E;
   localparam logic [7:0] TYPE_START = 8'h78;

   // Control block types that close a frame (0..7 data octets before the end)
   localparam int N_TERM = 8;
   localparam logic [N_TERM-1:0][7:0] TERM_TYPES = {
      8'hFF, 8'hE1, 8'hD2, 8'hCC, 8'hB4, 8'hAA, 8'h99, 8'h87
   };

   localparam logic [BLK_W-1:0] IDLE_BLK = {SYNC_CTRL, TYPE_IDLE, 56'h0};

endpackage

// File: rtl/rir_frame_track.sv
// Write-side frame tracker: finds start/terminate control blocks and counts
// the parity regions cut out of the frame in progress.
module rir_frame_track
   import rx_idle_restore_pkg::*;
#(
   parameter int MAX_REGIONS = 8,
   parameter int OWED_W      = $clog2(MAX_REGIONS + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [9:0]        hdr,          // sync header and type byte
   input  logic              parity_cut,
   output logic [OWED_W-1:0] owed,         // regions owed, non-zero only on terminate
   output logic              excess        // marker beyond the per-frame limit
);

   localparam logic [OWED_W-1:0] CAP = OWED_W'(MAX_REGIONS);

   logic [N_TERM-1:0] term_hit;
   logic              is_ctrl, is_term, is_start, at_cap;
   logic [OWED_W-1:0] cnt_q, base, cnt_d;

   genvar gi;
   generate
      for (gi = 0; gi < N_TERM; gi++) begin : g_term
         assign term_hit[gi] = (hdr[7:0] == TERM_TYPES[gi]);
      end
   endgenerate

   assign is_ctrl  = (hdr[9:8] == SYNC_CTRL);
   assign is_term  = in_valid & is_ctrl & (|term_hit);
   assign is_start = in_valid & is_ctrl & (hdr[7:0] == TYPE_START);

   // A start block opens a new frame; markers in that cycle belong to it.
   assign base   = is_start ? '0 : cnt_q;
   assign at_cap = (base == CAP);
   assign cnt_d  = base + OWED_W'(parity_cut & ~at_cap);
   assign excess = parity_cut & at_cap;
   assign owed   = is_term ? cnt_d : '0;

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_d;
   end

   p_owed_cap_r8: assert property (@(posedge clk) disable iff (rst)
      owed <= CAP);

   p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
      (is_start && !parity_cut) |=> (cnt_q == '0));

endmodule

// File: rtl/rir_fifo.sv
// Block FIFO with a registered fill level and combinational read data.
module rir_fifo #(
   parameter int W     = 70,
   parameter int DEPTH = 64,
   parameter int AW    = $clog2(DEPTH),
   parameter int LVL_W = AW + 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_req,
   input  logic [W-1:0]     wr_data,
   input  logic             rd_en,
   output logic [W-1:0]     rd_data,
   output logic [LVL_W-1:0] level,
   output logic             full_drop
);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic          full, wr_en;

   assign full      = (level == LVL_W'(DEPTH));
   assign wr_en     = wr_req & ~full;
   assign full_drop = wr_req & full;
   assign rd_data   = mem[rp];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wp] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (wr_en) wp <= wp + AW'(1);
         if (rd_en) rp <= rp + AW'(1);
         level <= level + LVL_W'(wr_en) - LVL_W'(rd_en);
      end
   end

   p_no_read_empty_r3: assert property (@(posedge clk) disable iff (rst)
      rd_en |-> (level != '0));

   p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
      level <= LVL_W'(DEPTH));

endmodule

// File: rtl/rir_idle_gen.sv
// Read side: waits for priming, then emits one block per cycle, pausing
// FIFO reads while the IDLEs owed for a finished frame go out.
module rir_idle_gen
   import rx_idle_restore_pkg::*;
#(
   parameter int PRIME  = 32,
   parameter int BPR    = 4,
   parameter int OWED_W = 4,
   parameter int IW     = 6,
   parameter int LVL_W  = 7
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LVL_W-1:0]  level,
   input  logic [BLK_W-1:0]  rd_blk,
   input  logic [OWED_W-1:0] rd_owed,
   output logic              rd_en,
   output logic              out_valid,
   output logic [BLK_W-1:0]  out_block
);

   logic          primed;
   logic [IW-1:0] idle_left;
   logic [IW-1:0] load;

   assign load  = IW'(rd_owed) * IW'(BPR);
   assign rd_en = primed & (idle_left == '0) & (level != '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         primed    <= 1'b0;
         out_valid <= 1'b0;
         idle_left <= '0;
         out_block <= IDLE_BLK;
      end else begin
         primed    <= primed | (level >= LVL_W'(PRIME));
         out_valid <= primed;
         if (idle_left != '0) begin
            out_block <= IDLE_BLK;
            idle_left <= idle_left - IW'(1);
         end else if (rd_en) begin
            out_block <= rd_blk;
            idle_left <= load;
         end else begin
            out_block <= IDLE_BLK;
         end
      end
   end

   p_idle_out_r4: assert property (@(posedge clk) disable iff (rst)
      (idle_left != '0) |=> (out_block == IDLE_BLK));

   p_valid_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> out_valid);

endmodule

// File: rtl/rx_idle_restore.sv
module rx_idle_restore
   import rx_idle_restore_pkg::*;
#(
   parameter int MAX_REGIONS       = 8,
   parameter int BLOCKS_PER_REGION = 4,
   parameter int PRIME             = MAX_REGIONS * BLOCKS_PER_REGION,
   parameter int DEPTH             = 2 * PRIME
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [BLK_W-1:0] in_block,
   input  logic             in_parity_cut,
   output logic             out_valid,
   output logic [BLK_W-1:0] out_block,
   output logic             overflow
);

   localparam int OWED_W = $clog2(MAX_REGIONS + 1);
   localparam int IW     = $clog2(MAX_REGIONS * BLOCKS_PER_REGION + 1);
   localparam int AW     = $clog2(DEPTH);
   localparam int LVL_W  = AW + 1;
   localparam int ENT_W  = BLK_W + OWED_W;

   generate
      if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (PRIME + 1 > DEPTH) begin : g_bad_prime
         $error("DEPTH must exceed PRIME");
      end
      if (MAX_REGIONS < 1 || BLOCKS_PER_REGION < 1) begin : g_bad_region
         $error("region parameters must be positive");
      end
   endgenerate

   logic [OWED_W-1:0] wr_owed;
   logic              excess, full_drop, rd_en;
   logic [ENT_W-1:0]  rd_ent;
   logic [LVL_W-1:0]  level;

   rir_frame_track #(
      .MAX_REGIONS(MAX_REGIONS), .OWED_W(OWED_W)
   ) u_track (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .hdr(in_block[65:56]), .parity_cut(in_parity_cut),
      .owed(wr_owed), .excess(excess)
   );

   rir_fifo #(
      .W(ENT_W), .DEPTH(DEPTH), .AW(AW), .LVL_W(LVL_W)
   ) u_fifo (
      .clk(clk), .rst(rst), .wr_req(in_valid),
      .wr_data({wr_owed, in_block}), .rd_en(rd_en),
      .rd_data(rd_ent), .level(level), .full_drop(full_drop)
   );

   rir_idle_gen #(
      .PRIME(PRIME), .BPR(BLOCKS_PER_REGION), .OWED_W(OWED_W),
      .IW(IW), .LVL_W(LVL_W)
   ) u_gen (
      .clk(clk), .rst(rst), .level(level),
      .rd_blk(rd_ent[BLK_W-1:0]), .rd_owed(rd_ent[ENT_W-1:BLK_W]),
      .rd_en(rd_en), .out_valid(out_valid), .out_block(out_block)
   );

   always_ff @(posedge clk) begin
      if (rst) overflow <= 1'b0;
      else     overflow <= overflow | excess | full_drop;
   end

   p_prefill_idle_r2: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (out_block == IDLE_BLK));

   p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

   p_empty_gives_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && level == '0 && !in_valid) |=> (out_block == IDLE_BLK));

endmodule

// File: tb/sim_rx_idle_restore.sv
module sim_rx_idle_restore;

   localparam int PRIME = 32;
   localparam logic [65:0] IDLE = {2'b10, 8'h1E, 56'h0};
   localparam logic [7:0] TT [8] = '{8'h87, 8'h99, 8'hAA, 8'hB4,
                                     8'hCC, 8'hD2, 8'hE1, 8'hFF};

   // Frame table: data blocks, regions cut inside, markers before the start
   localparam int FR_N = 6;
   localparam int FR_LEN [FR_N] = '{6, 20, 3, 40, 2, 12};
   localparam int FR_REG [FR_N] = '{0,  1, 3,  8, 0,  2};
   localparam int FR_PRE [FR_N] = '{0,  0, 0,  0, 2,  0};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [65:0] in_block = IDLE;
   logic        in_parity_cut = 1'b0;
   logic        out_valid;
   logic [65:0] out_block;
   logic        overflow;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit chk_en = 1'b0;
   bit seen_valid = 1'b0;
   bit done = 1'b0;
   int start_d [FR_N];
   logic [65:0] expq [$];

   rx_idle_restore u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
      .in_parity_cut(in_parity_cut), .out_valid(out_valid),
      .out_block(out_block), .overflow(overflow)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req,
                        input logic [65:0] act, input logic [65:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   function automatic logic [65:0] start_blk(int fid);
      return {2'b10, 8'h78, 48'h0, 8'(fid)};
   endfunction
   function automatic logic [65:0] data_blk(int fid, int i);
      return {2'b01, 32'(fid), 32'(i)};
   endfunction
   function automatic logic [65:0] term_blk(int fid);
      return {2'b10, TT[fid % 8], 56'(fid)};
   endfunction

   task automatic drive(input bit v, input logic [65:0] b, input bit mark);
      @(negedge clk);
      in_valid      = v;
      in_block      = b;
      in_parity_cut = mark;
      if (v) begin
         expq.push_back(b);
         if (b[65:56] == {2'b10, 8'h78}) start_d[b[7:0]] = cyc;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0; in_block = IDLE; in_parity_cut = 1'b0;
      repeat (3) @(negedge clk);
      // R1 R10: values while reset is held
      check(out_valid == 1'b0, "R1 out_valid", 66'(out_valid), 66'd0);
      check(out_block == IDLE, "R1 out_block", out_block, IDLE);
      check(overflow == 1'b0, "R1 overflow", 66'(overflow), 66'd0);
      rst = 1'b0;
   endtask

   task automatic send_frame(input int fid);
      for (int p = 0; p < FR_PRE[fid]; p++) drive(1'b1, IDLE, 1'b1); // R6
      drive(1'b1, start_blk(fid), 1'b0);
      drive(1'b1, data_blk(fid, 0), 1'b0);
      for (int r = 0; r < FR_REG[fid]; r++) begin
         drive(1'b0, IDLE, 1'b1);
         for (int g = 0; g < 3; g++) drive(1'b0, IDLE, 1'b0);
      end
      for (int i = 1; i < FR_LEN[fid]; i++) drive(1'b1, data_blk(fid, i), 1'b0);
      drive(1'b1, term_blk(fid), 1'b0);
      for (int k = 0; k < 4 * FR_REG[fid]; k++) expq.push_back(IDLE); // R4
      for (int k = 0; k < 40; k++) drive(1'b1, IDLE, 1'b0);
   endtask

   // Stream checker: every output cycle against the expected stream
   always @(negedge clk) begin
      if (chk_en) begin
         if (seen_valid)
            check(out_valid == 1'b1, "R7 out_valid held", 66'(out_valid), 66'd1);
         if (out_valid) begin
            logic [65:0] e;
            e = (expq.size() != 0) ? expq.pop_front() : IDLE;
            if (!seen_valid) begin
               seen_valid = 1'b1;
               // R2: first block is frame 0 start, PRIME+1 edges after write
               check(cyc - (start_d[0] + 1) == PRIME + 1, "R2 first latency",
                     66'(cyc - (start_d[0] + 1)), 66'(PRIME + 1));
            end
            check(out_block == e, "R3 R4 stream", out_block, e);
            if (out_block[65:56] == {2'b10, 8'h78} && out_block[7:0] < FR_N) begin
               int fid;
               fid = int'(out_block[7:0]);
               check(cyc - (start_d[fid] + 1) == PRIME + 1, "R5 start latency",
                     66'(cyc - (start_d[fid] + 1)), 66'(PRIME + 1));
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      do_reset();
      chk_en = 1'b1;
      for (int f = 0; f < FR_N; f++) send_frame(f);
      // R7: input stops, stream drains and keeps running on IDLE
      for (int k = 0; k < 80; k++) drive(1'b0, IDLE, 1'b0);
      check(expq.size() == 0, "R3 all blocks out", 66'(expq.size()), 66'd0);
      chk_en = 1'b0;
      seen_valid = 1'b0;

      // R8: ninth region inside one frame
      do_reset();
      drive(1'b1, start_blk(0), 1'b0);
      for (int k = 0; k < 8; k++) drive(1'b1, data_blk(0, k), 1'b1);
      drive(1'b0, IDLE, 1'b0);
      check(overflow == 1'b0, "R8 eight regions ok", 66'(overflow), 66'd0);
      drive(1'b1, data_blk(0, 8), 1'b1);
      drive(1'b0, IDLE, 1'b0);
      check(overflow == 1'b1, "R8 ninth region", 66'(overflow), 66'd1);

      // R9: markers without gaps make the IDLE stall fill the FIFO
      do_reset();
      drive(1'b1, start_blk(1), 1'b0);
      for (int k = 0; k < 8; k++) drive(1'b1, data_blk(1, k), 1'b1);
      drive(1'b1, term_blk(1), 1'b0);
      drive(1'b1, IDLE, 1'b0);
      check(overflow == 1'b0, "R9 before stall", 66'(overflow), 66'd0);
      for (int k = 0; k < 80; k++) drive(1'b1, IDLE, 1'b0);
      check(overflow == 1'b1, "R9 full write", 66'(overflow), 66'd1);
      for (int k = 0; k < 20; k++) drive(1'b0, IDLE, 1'b0);
      check(overflow == 1'b1, "R9 sticky", 66'(overflow), 66'd1);

      // R10: reset mid-stream, nothing old comes back
      do_reset();
      for (int k = 0; k < 50; k++) begin
         drive(1'b0, IDLE, 1'b0);
         check(out_valid == 1'b0 && out_block == IDLE, "R10 flushed",
               out_block, IDLE);
      end
      check(overflow == 1'b0, "R1 overflow after reset", 66'(overflow), 66'd0);
      finish_run();
   end

endmodule